// File: doc/BRIEF.md
# Receive Line Break Detector

This block watches a serial receive line that idles high and tells the rest of the receiver when the far end has held the line low for an abnormally long time. Such a condition usually means a disconnected cable or a peer that has gone into reset. The line is looked at only on a sixteen-times oversample tick, so one bit time equals sixteen ticks. The input is expected to be already synchronised to the block clock.

The break threshold is a whole number of character times. A 2-bit select picks 2, 4, 8 or 16 characters. One character is 10 bit times, or 11 when a parity bit is framed. A break is reported once the line has been low on more consecutive ticks than the threshold. The block then raises a status level for as long as the break lasts and emits a single-cycle event for interrupt logic. Only one event is produced per break. Both the status and the ability to fire again come back only after the line has been high for half a bit time, which is eight consecutive ticks.

Top module: `rx_break_monitor`

## Requirements
- R1: After reset, `brk_active_o` and `brk_event_o` are both low.
- R2: `brk_sel_i` selects the threshold in characters: 0 gives 2, 1 gives 4, 2 gives 8 and 3 gives 16.
- R3: One character time is 10 bit times of 16 ticks each (160 ticks) when `parity_en_i` is 0, and 11 bit times (176 ticks) when it is 1.
- R4: A break is declared on the tick that makes the number of consecutive low ticks exceed the threshold (threshold + 1 low ticks). In the cycle after that tick, `brk_event_o` and `brk_active_o` are both high. At exactly the threshold, neither is asserted.
- R5: Any tick on which `line_i` is high restarts the low-tick count from zero.
- R6: Only one event is produced per break, however long the line then stays low.
- R7: After a break, a new event can only be produced once `line_i` has been high on 8 consecutive ticks. A high run shorter than 8 ticks, followed by a long low stretch, produces no event.
- R8: `brk_active_o` falls in the cycle after the 8th consecutive high tick, which is the same moment the detector re-arms.
- R9: `line_i` is only looked at on cycles where `os_tick_i` is high. Low cycles without a tick neither count nor change `brk_active_o`.
- R10: `brk_event_o` is high for exactly one clock cycle per break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Synchronised receive line, idle high |
| os_tick_i | input | 1 | Sixteen-times oversample tick, one clock wide |
| brk_sel_i | input | 2 | Break threshold select (2/4/8/16 characters) |
| parity_en_i | input | 1 | Parity bit present in the character frame |
| brk_active_o | output | 1 | High while a detected break is in progress |
| brk_event_o | output | 1 | One-cycle pulse when a break is detected |

## Verification
The bench drives exactly the threshold number of low ticks for every select value, with and without parity, and then one more tick. A design with a greater-or-equal compare fires one tick early, and a wrong character length or level decode fires at the wrong count. It holds the line low for thousands of ticks past detection to catch a counter that wraps or re-fires. It also interrupts breaks with seven high ticks to catch re-arming too early, and inserts a single high tick inside a long low run to catch a count that does not restart. Finally, it holds the line low with no ticks to catch a detector that counts clocks instead of ticks.

// File: rtl/brk_pkg.sv
package brk_pkg;
  // Bit times per character without and with a parity bit.
  localparam int unsigned CHAR_BITS_PLAIN  = 10;
  localparam int unsigned CHAR_BITS_PARITY = 11;

  // Low-tick counter width large enough for the largest threshold plus one.
  function automatic int unsigned cnt_width(int unsigned ovs, int unsigned sel_w);
    int unsigned max_chars;
    max_chars = 2 << ((1 << sel_w) - 1);
    return $clog2(max_chars * CHAR_BITS_PARITY * ovs + 2);
  endfunction
endpackage

// File: rtl/brk_threshold.sv
module brk_threshold #(
  parameter int unsigned OVS   = 16,
  parameter int unsigned SEL_W = 2,
  parameter int unsigned CNT_W = 12
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             parity_en_i,
  output logic [CNT_W-1:0] thr_o
);
  import brk_pkg::*;

  int unsigned chars;
  int unsigned bits_per_char;

  always_comb begin
    chars         = 32'd2 << sel_i;
    bits_per_char = parity_en_i ? CHAR_BITS_PARITY : CHAR_BITS_PLAIN;
    thr_o         = CNT_W'(chars * bits_per_char * OVS);
  end
endmodule

// File: rtl/brk_low_timer.sv
module brk_low_timer #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             line_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             over_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // Count only on ticks; a high sample restarts, a count past thr holds.
  assign cnt_en = tick_i;

  always_comb begin
    cnt_d = cnt_q;
    if (line_i) begin
      cnt_d = '0;
    end else if (cnt_q <= thr_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // The low tick that takes the run beyond the threshold.
  assign over_o = tick_i && !line_i && (cnt_q >= thr_i);
endmodule

// File: rtl/brk_high_timer.sv
module brk_high_timer #(
  parameter int unsigned HALF_TICKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  output logic rearm_o
);
  localparam int unsigned HW = $clog2(HALF_TICKS + 1);
  localparam logic [HW-1:0] LAST = HW'(HALF_TICKS - 1);

  logic [HW-1:0] hi_q, hi_d;
  logic          hi_en;

  assign hi_en = tick_i;

  always_comb begin
    hi_d = hi_q;
    if (!line_i) begin
      hi_d = '0;
    end else if (hi_q <= LAST) begin
      hi_d = hi_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
    end else if (hi_en) begin
      hi_q <= hi_d;
    end
  end

  // The high tick that completes half a bit time of idle line.
  assign rearm_o = tick_i && line_i && (hi_q == LAST);
endmodule

// File: rtl/rx_break_monitor.sv
module rx_break_monitor #(
  parameter int unsigned OVS   = 16,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic             os_tick_i,
  input  logic [SEL_W-1:0] brk_sel_i,
  input  logic             parity_en_i,
  output logic             brk_active_o,
  output logic             brk_event_o
);
  localparam int unsigned CNT_W      = brk_pkg::cnt_width(OVS, SEL_W);
  localparam int unsigned HALF_TICKS = OVS / 2;

  logic [CNT_W-1:0] thr;
  logic             over, rearm;
  logic             active_q, active_d;
  logic             event_q, event_d;

  brk_threshold #(.OVS(OVS), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_thr (
    .sel_i       (brk_sel_i),
    .parity_en_i (parity_en_i),
    .thr_o       (thr)
  );

  brk_low_timer #(.CNT_W(CNT_W)) u_low (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (os_tick_i),
    .line_i (line_i),
    .thr_i  (thr),
    .over_o (over)
  );

  brk_high_timer #(.HALF_TICKS(HALF_TICKS)) u_high (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (os_tick_i),
    .line_i  (line_i),
    .rearm_o (rearm)
  );

  // Not active means armed: one event, then silence until re-armed.
  always_comb begin
    active_d = active_q;
    event_d  = 1'b0;
    if (over && !active_q) begin
      active_d = 1'b1;
      event_d  = 1'b1;
    end else if (rearm) begin
      active_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      event_q  <= 1'b0;
    end else begin
      active_q <= active_d;
      event_q  <= event_d;
    end
  end

  assign brk_active_o = active_q;
  assign brk_event_o  = event_q;
endmodule

// File: rtl/rx_break_monitor_chk.sv
module rx_break_monitor_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic line_i,
  input logic os_tick_i,
  input logic brk_active_o,
  input logic brk_event_o
);
  a_r10_event_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_event_o |=> !brk_event_o);

  a_r4_event_after_low_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_event_o |-> $past(os_tick_i && !line_i));

  a_r4_active_rises_with_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_active_o) |-> brk_event_o);

  a_r6_event_only_when_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_event_o |-> !$past(brk_active_o));

  a_r8_clear_after_high_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(brk_active_o) |-> $past(os_tick_i && line_i));

  a_r9_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !os_tick_i |=> $stable(brk_active_o));
endmodule

bind rx_break_monitor rx_break_monitor_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .line_i       (line_i),
  .os_tick_i    (os_tick_i),
  .brk_active_o (brk_active_o),
  .brk_event_o  (brk_event_o)
);

// File: tb/rx_break_monitor_tb.sv
module rx_break_monitor_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, line, tick, par;
  logic [1:0] sel;
  logic       active, event_o;
  int checks = 0, errors = 0, ev_cnt = 0;

  rx_break_monitor dut_i (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .os_tick_i(tick),
    .brk_sel_i(sel), .parity_en_i(par),
    .brk_active_o(active), .brk_event_o(event_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rst_n && event_o) ev_cnt++;

  function automatic int thr_ticks(int s, bit p);
    return (2 << s) * (p ? 11 : 10) * 16;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at a negedge with the tick's effect visible.
  task automatic tick1(bit v);
    line = v; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic run(bit v, int n);
    for (int i = 0; i < n; i++) tick1(v);
  endtask

  task automatic t_reset();
    chk("R1 active", active, 0);
    chk("R1 event", event_o, 0);
  endtask

  task automatic t_basic();
    int base;
    sel = 2'd0; par = 1'b0;
    line = 1'b0;
    repeat (3000) @(negedge clk);
    chk("R9 no count without tick", ev_cnt, 0);
    chk("R9 active without tick", active, 0);
    base = ev_cnt;
    run(0, thr_ticks(0, 0));
    chk("R4 none at threshold", ev_cnt - base, 0);
    chk("R4 active at threshold", active, 0);
    run(0, 1);
    chk("R4 event past threshold", ev_cnt - base, 1);
    chk("R4 active past threshold", active, 1);
    chk("R10 pulse already gone", event_o, 0);
    run(0, 2000);
    chk("R6 single event in long break", ev_cnt - base, 1);
    chk("R6 active held", active, 1);
    run(1, 7);
    chk("R8 active after 7 high", active, 1);
    run(1, 1);
    chk("R8 active after 8 high", active, 0);
  endtask

  task automatic t_no_early_rearm();
    int base;
    base = ev_cnt;
    run(0, thr_ticks(0, 0) + 1);
    chk("R7 first break", ev_cnt - base, 1);
    run(1, 7);
    run(0, 500);
    chk("R7 no event after short high", ev_cnt - base, 1);
    chk("R7 active stays", active, 1);
    run(1, 8);
    run(0, thr_ticks(0, 0) + 1);
    chk("R7 event after full re-arm", ev_cnt - base, 2);
    run(1, 8);
  endtask

  task automatic t_low_restart();
    int base;
    base = ev_cnt;
    run(0, thr_ticks(0, 0));
    run(1, 1);
    run(0, thr_ticks(0, 0));
    chk("R5 high tick restarts count", ev_cnt - base, 0);
    run(0, 1);
    chk("R5 event after restarted run", ev_cnt - base, 1);
    run(1, 8);
  endtask

  task automatic t_parity();
    int base;
    sel = 2'd0; par = 1'b1;
    base = ev_cnt;
    run(0, thr_ticks(0, 1));
    chk("R3 parity none at 352", ev_cnt - base, 0);
    run(0, 1);
    chk("R3 parity event at 353", ev_cnt - base, 1);
    run(1, 8);
    chk("R8 parity cleared", active, 0);
  endtask

  task automatic t_levels();
    int base;
    for (int k = 1; k < 5; k++) begin
      sel = (k == 4) ? 2'd3 : 2'(k);
      par = (k == 4);
      base = ev_cnt;
      run(0, thr_ticks(int'(sel), par));
      chk("R2 none at level threshold", ev_cnt - base, 0);
      run(0, 1);
      chk("R2 event past level threshold", ev_cnt - base, 1);
      run(1, 8);
    end
  endtask

  initial begin
    rst_n = 1'b0; line = 1'b1; tick = 1'b0; sel = 2'd0; par = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_no_early_rearm();
    t_low_restart();
    t_parity();
    t_levels();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule